// File: doc/BRIEF.md
# Multiphase Coarse-Fine Time Interval Meter

This block measures the time from a rising edge on a start input to a rising edge on a stop input. A period counter running on the reference clock supplies the whole-period part of the interval. The sub-period part comes from a set of equally spaced phases of that clock: each phase samples both inputs, and the pattern of phases that have or have not yet seen an edge places the edge within one period. The two parts are merged into one value counted in phase steps, so one LSB equals the reference period divided by the number of phases. For example, eight phases of a 200 MHz clock give 625 ps, and the same eight phases at 400 MHz give 312.5 ps.

A calibration offset taken from an input port is subtracted from every result to remove a fixed systematic error. The corrected value appears on a held output with a one-cycle strobe. The same value can be read a byte at a time through a small select port, which suits a byte-serial link to a host. The phase clocks are inputs. Index 0 is the reference clock and clocks all of the control logic.

Top module: `mpc_tdc`

## Requirements
- R1: The fine code of an edge is the number of phases that have not yet sampled it (binary 0 to NPH-1). The interval equals coarse × NPH + fine_stop − fine_start, so an edge first seen by phase sample g (counting phase samples in time order) and a stop first seen by sample h give h − g before correction.
- R2: The coarse part is the number of whole reference periods between the clock cycles in which the start and the stop edges are detected.
- R3: The value cal_offset is subtracted from every interval. If the difference is negative, the result is 0.
- R4: Each measurement produces result_valid high for exactly one cycle. result and overflow keep their value until the next strobe.
- R5: busy rises when a start is accepted. It stays high until the result is delivered and falls in the same cycle that result_valid rises.
- R6: A stop edge while no measurement is running produces no result, leaves busy low, and does not disturb the next measurement.
- R7: A start edge during a running measurement is ignored. The result is referenced to the first start.
- R8: If the coarse counter reaches its maximum (2^CW − 1 periods) without a stop, the measurement ends with overflow = 1 and result all ones. A stop detected exactly at the maximum count is still measured normally.
- R9: If start and stop edges are detected in the same cycle while idle, the interval is measured with coarse 0 when fine_stop ≥ fine_start. Otherwise the stop is treated as earlier than the start and is ignored.
- R10: rd_byte shows byte rd_sel of result one cycle after rd_sel is applied, with select 0 giving bits 7:0. A select at or above the byte count gives 0.
- R11: After reset, busy, result_valid, overflow and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ph_clk | input | NPH | Phase clocks, equally spaced; bit 0 is the reference clock |
| rst | input | 1 | Synchronous active-high reset (reference clock domain) |
| start_in | input | 1 | Start event, rising edge marks the start time |
| stop_in | input | 1 | Stop event, rising edge marks the stop time |
| cal_offset | input | OFS_W | Calibration value subtracted from each interval |
| rd_sel | input | SELW | Byte select for the byte readout |
| result | output | RES_W | Corrected interval in phase steps, held |
| result_valid | output | 1 | One-cycle strobe for a new result |
| overflow | output | 1 | Set with the result when the coarse counter saturated |
| busy | output | 1 | High from accepted start until the result is delivered |
| rd_byte | output | 8 | Selected byte of the result, registered |

## Verification
Both edge detectors can fire in the same reference cycle. In that case the idle controller must pick between measuring immediately with a zero coarse count and discarding the stop as early. The bench provokes this by placing both edges inside one period, in both orders and with equal phase positions. It judges the result by the value h − g for the forward order and for the tie. For the reversed order, the discarded stop leaves the measurement running, so the bench judges it by the overflow outcome.

// File: rtl/mpc_tdc_pkg.sv
`timescale 1ps/1ps
package mpc_tdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CALC = 2'd2
  } tdc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mpc_tdc_sampler.sv
`timescale 1ps/1ps
// Samples one event input on every phase, moves the pattern into the
// reference domain and reports a rising edge with its sub-period code.
module mpc_tdc_sampler #(
  parameter int NPH = 8,
  parameter int FW  = $clog2(NPH)
) (
  input  logic [NPH-1:0] ph_clk,
  input  logic           rst,
  input  logic           sig_in,
  output logic           edge_o,
  output logic [FW-1:0]  fine_o
);
  localparam int ZW = FW + 1;

  logic [NPH-1:0] tap;
  logic [NPH-1:0] thermo_q;
  logic           last_q;
  logic [ZW-1:0]  zeros;

  // one capture flop per phase, each in its own clock domain
  for (genvar i = 0; i < NPH; i++) begin : g_tap
    logic q;
    always_ff @(posedge ph_clk[i]) begin
      if (rst) q <= 1'b0;
      else     q <= sig_in;
    end
    assign tap[i] = q;
  end

  // count phases that did not yet see the level (thermometer to binary)
  always_comb begin
    zeros = '0;
    for (int i = 0; i < NPH; i++) begin
      if (!thermo_q[i]) zeros = zeros + ZW'(1);
    end
  end

  always_ff @(posedge ph_clk[0]) begin
    if (rst) begin
      thermo_q <= '0;
      last_q   <= 1'b1;
      edge_o   <= 1'b0;
      fine_o   <= '0;
    end else begin
      thermo_q <= tap;
      last_q   <= thermo_q[NPH-1];
      edge_o   <= (|thermo_q) && !last_q;
      fine_o   <= zeros[FW-1:0];
    end
  end

endmodule

// File: rtl/mpc_tdc_coarse.sv
`timescale 1ps/1ps
// Whole-period counter with saturation detect.
module mpc_tdc_coarse #(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          sat
);
  assign sat = (cnt == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (clr)          cnt <= CW'(1);
    else if (adv && !sat)  cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/mpc_tdc_combine.sv
`timescale 1ps/1ps
// Two-stage arithmetic: merge coarse and fine, then correct and clamp.
module mpc_tdc_combine
  import mpc_tdc_pkg::*;
#(
  parameter int NPH   = 8,
  parameter int CW    = 21,
  parameter int OFS_W = 8,
  parameter int RES_W = 24,
  parameter int FW    = $clog2(NPH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             ovf_in,
  input  logic [CW-1:0]    coarse,
  input  logic [FW-1:0]    fine_a,
  input  logic [FW-1:0]    fine_b,
  input  logic [OFS_W-1:0] ofs,
  output logic             res_valid,
  output logic [RES_W-1:0] res,
  output logic             res_ovf
);
  localparam int AW = imax(CW + FW + 2, OFS_W + 2);
  localparam int XW = imax(AW, RES_W + 2);

  logic [XW-1:0] sum;
  logic [XW-1:0] raw_q;
  logic [XW-1:0] corr;
  logic          ovf_q;
  logic          v1_q;

  // stage 1 input: coarse*NPH + fine_b - fine_a (two's complement)
  always_comb sum = XW'(coarse) * XW'(NPH) + XW'(fine_b) - XW'(fine_a);
  // stage 2 input: remove calibration offset
  always_comb corr = raw_q - XW'(ofs);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      ovf_q <= 1'b0;
      v1_q  <= 1'b0;
    end else begin
      v1_q <= load;
      if (load) begin
        raw_q <= sum;
        ovf_q <= ovf_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res       <= '0;
      res_ovf   <= 1'b0;
    end else begin
      res_valid <= v1_q;
      if (v1_q) begin
        res_ovf <= ovf_q;
        if (ovf_q)                  res <= '1;
        else if (corr[XW-1])        res <= '0;
        else if (|corr[XW-2:RES_W]) res <= '1;
        else                        res <= corr[RES_W-1:0];
      end
    end
  end

endmodule

// File: rtl/mpc_tdc.sv
`timescale 1ps/1ps
// Coarse-fine interval meter: controller, counter, two samplers, arithmetic.
module mpc_tdc
  import mpc_tdc_pkg::*;
#(
  parameter int NPH    = 8,
  parameter int CW     = 21,
  parameter int OFS_W  = 8,
  parameter int RES_W  = 24,
  parameter int NBYTES = (RES_W + 7) / 8,
  parameter int SELW   = (NBYTES > 1) ? $clog2(NBYTES + 1) : 1
) (
  input  logic [NPH-1:0]   ph_clk,
  input  logic             rst,
  input  logic             start_in,
  input  logic             stop_in,
  input  logic [OFS_W-1:0] cal_offset,
  input  logic [SELW-1:0]  rd_sel,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             overflow,
  output logic             busy,
  output logic [7:0]       rd_byte
);
  localparam int FW = $clog2(NPH);
  localparam int PW = NBYTES * 8;

  logic clk;
  assign clk = ph_clk[0];

  tdc_state_e     state;
  logic           st_edge, sp_edge;
  logic [FW-1:0]  st_fine, sp_fine, fa_q;
  logic [CW-1:0]  cnt;
  logic           sat;
  logic           clr, adv, load, ovf_in, same_ok;
  logic [CW-1:0]  coarse_sel;
  logic [FW-1:0]  fine_a_sel;
  logic [PW-1:0]  res_pad;

  mpc_tdc_sampler #(.NPH(NPH), .FW(FW)) u_start (
    .ph_clk(ph_clk), .rst(rst), .sig_in(start_in),
    .edge_o(st_edge), .fine_o(st_fine)
  );

  mpc_tdc_sampler #(.NPH(NPH), .FW(FW)) u_stop (
    .ph_clk(ph_clk), .rst(rst), .sig_in(stop_in),
    .edge_o(sp_edge), .fine_o(sp_fine)
  );

  mpc_tdc_coarse #(.CW(CW)) u_coarse (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .cnt(cnt), .sat(sat)
  );

  // same-cycle start and stop: stop counts only if not earlier than start
  assign same_ok = sp_edge && (sp_fine >= st_fine);

  always_comb begin
    clr        = 1'b0;
    adv        = 1'b0;
    load       = 1'b0;
    ovf_in     = 1'b0;
    coarse_sel = cnt;
    fine_a_sel = fa_q;
    unique case (state)
      ST_IDLE: begin
        clr        = st_edge;
        load       = st_edge && same_ok;
        coarse_sel = '0;
        fine_a_sel = st_fine;
      end
      ST_RUN: begin
        adv    = !sp_edge;
        load   = sp_edge || sat;
        ovf_in = !sp_edge && sat;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      fa_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (st_edge) begin
          fa_q  <= st_fine;
          state <= same_ok ? ST_CALC : ST_RUN;
        end
        ST_RUN:  if (sp_edge || sat) state <= ST_CALC;
        ST_CALC: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  mpc_tdc_combine #(.NPH(NPH), .CW(CW), .OFS_W(OFS_W), .RES_W(RES_W), .FW(FW)) u_comb (
    .clk(clk), .rst(rst), .load(load), .ovf_in(ovf_in),
    .coarse(coarse_sel), .fine_a(fine_a_sel), .fine_b(sp_fine), .ofs(cal_offset),
    .res_valid(result_valid), .res(result), .res_ovf(overflow)
  );

  // byte readout for a byte-serial host link
  assign res_pad = PW'(result);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
    end else begin
      rd_byte <= '0;
      for (int b = 0; b < NBYTES; b++) begin
        if (rd_sel == SELW'(b)) rd_byte <= res_pad[8*b +: 8];
      end
    end
  end

endmodule

// File: rtl/mpc_tdc_chk.sv
`timescale 1ps/1ps
module mpc_tdc_chk #(
  parameter int RES_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             result_valid,
  input logic             overflow,
  input logic [RES_W-1:0] result
);

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> ($stable(result) && $stable(overflow)));

  assert_busy_low_on_valid_R5: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);

  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> result_valid);

  assert_valid_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(result_valid) |-> $past(busy));

  assert_ovf_ones_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (result == {RES_W{1'b1}}));

endmodule

bind mpc_tdc mpc_tdc_chk #(.RES_W(RES_W)) u_chk (
  .clk(ph_clk[0]), .rst(rst), .busy(busy), .result_valid(result_valid),
  .overflow(overflow), .result(result)
);

// File: tb/mpc_tdc_bench.sv
`timescale 1ps/1ps
module mpc_tdc_bench;
  localparam int CLK_PERIOD = 5000;
  localparam int NPH   = 8;
  localparam int STEP  = CLK_PERIOD / NPH;
  localparam int CW    = 8;
  localparam int OFS_W = 8;
  localparam int RES_W = 24;
  localparam int SELW  = 2;
  localparam longint MAXC    = (64'd1 << CW) - 1;
  localparam longint RES_MAX = (64'd1 << RES_W) - 1;

  logic [NPH-1:0]   ph;
  logic             rst = 1'b1;
  logic             start_in = 1'b0;
  logic             stop_in = 1'b0;
  logic [OFS_W-1:0] cal_offset = '0;
  logic [SELW-1:0]  rd_sel = '0;
  logic [RES_W-1:0] result;
  logic             result_valid, overflow, busy;
  logic [7:0]       rd_byte;

  int n_checks = 0;
  int n_fail   = 0;
  int n_valid  = 0;
  bit done     = 1'b0;
  longint cap_res = 0;
  bit cap_ovf  = 1'b0;
  bit cap_busy = 1'b0;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic p;
    initial begin
      p = 1'b0;
      #(CLK_PERIOD + i * STEP);
      forever begin
        p = 1'b1; #(CLK_PERIOD / 2);
        p = 1'b0; #(CLK_PERIOD / 2);
      end
    end
    assign ph[i] = p;
  end

  mpc_tdc #(.NPH(NPH), .CW(CW), .OFS_W(OFS_W), .RES_W(RES_W)) u_mpc_tdc (
    .ph_clk(ph), .rst(rst), .start_in(start_in), .stop_in(stop_in),
    .cal_offset(cal_offset), .rd_sel(rd_sel), .result(result),
    .result_valid(result_valid), .overflow(overflow), .busy(busy), .rd_byte(rd_byte)
  );

  always @(negedge ph[0]) begin
    if (!rst && result_valid) begin
      n_valid  = n_valid + 1;
      cap_res  = longint'(result);
      cap_ovf  = overflow;
      cap_busy = busy;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input longint ga, input longint gp, input bit stp,
                                input int ofs, output longint r, output bit o);
    longint c;
    if (!stp || gp < ga || (gp / NPH - ga / NPH) > MAXC) begin
      r = RES_MAX; o = 1'b1;
    end else begin
      c = gp - ga - ofs;
      o = 1'b0;
      r = (c < 0) ? 0 : ((c > RES_MAX) ? RES_MAX : c);
    end
  endfunction

  // ga_rel/gp_rel: phase steps after a reference edge; s2_rel: extra start, -1 none
  task automatic run_meas(input int ga_rel, input int gp_rel, input bit stp,
                          input int s2_rel, input int ofs, input string req);
    longint t0, g0, ga, gp, er;
    bit eo;
    int ta, tp, wc;
    cal_offset = OFS_W'(ofs);
    n_valid = 0;
    @(posedge ph[0]);
    t0 = $time;
    g0 = t0 / STEP;
    ta = ga_rel * STEP + 100 + int'($urandom_range(0, 399));
    tp = gp_rel * STEP + 100 + int'($urandom_range(0, 399));
    ga = g0 + ga_rel + 1;
    gp = g0 + gp_rel + 1;
    model(ga, gp, stp, ofs, er, eo);
    fork
      begin #(ta) start_in = 1'b1; #(2 * CLK_PERIOD) start_in = 1'b0; end
      begin
        if (s2_rel >= 0) begin
          #(ta + s2_rel * STEP) start_in = 1'b1; #(2 * CLK_PERIOD) start_in = 1'b0;
        end
      end
      begin
        if (stp) begin #(tp) stop_in = 1'b1; #(2 * CLK_PERIOD) stop_in = 1'b0; end
      end
      begin
        if (eo || (gp - ga > 48)) begin
          #(ta + 4 * CLK_PERIOD);
          chk("R5 busy during measurement", longint'(busy), 1);
        end
      end
    join
    wc = eo ? int'(MAXC) + 12 : 12;
    repeat (wc) @(posedge ph[0]);
    @(negedge ph[0]);
    chk({req, " result"}, cap_res, er);
    chk("R8 overflow flag", longint'(cap_ovf), longint'(eo));
    chk("R4 single strobe", n_valid, 1);
    chk("R5 busy low at strobe", longint'(cap_busy), 0);
    chk("R4 result held", longint'(result), er);
  endtask

  task automatic chk_byte(input int sel, input longint exp);
    @(negedge ph[0]);
    rd_sel = SELW'(sel);
    @(negedge ph[0]);
    chk("R10 byte readout", longint'(rd_byte), exp);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (6) @(posedge ph[0]);
    @(negedge ph[0]);
    rst = 1'b0;
    // R11 reset state
    chk("R11 busy", longint'(busy), 0);
    chk("R11 valid", longint'(result_valid), 0);
    chk("R11 overflow", longint'(overflow), 0);
    chk("R11 result", longint'(result), 0);

    // R6: stop with no start
    n_valid = 0;
    @(posedge ph[0]);
    #(1300) stop_in = 1'b1;
    #(2 * CLK_PERIOD) stop_in = 1'b0;
    repeat (10) @(posedge ph[0]);
    @(negedge ph[0]);
    chk("R6 no result from lone stop", n_valid, 0);
    chk("R6 busy stays low", longint'(busy), 0);
    run_meas(2, 30, 1'b1, -1, 0, "R6 next measurement");

    // R1/R2 directed
    run_meas(0, 7, 1'b1, -1, 0, "R1");
    run_meas(7, 8, 1'b1, -1, 0, "R2");
    run_meas(3, 83, 1'b1, -1, 0, "R2");

    // R3 offset and clamp
    run_meas(0, 10, 1'b1, -1, 3, "R3 offset");
    run_meas(0, 10, 1'b1, -1, 10, "R3 zero");
    run_meas(0, 10, 1'b1, -1, 20, "R3 clamp");

    // R9 same-cycle detection
    run_meas(1, 5, 1'b1, -1, 0, "R9 same cycle forward");
    run_meas(3, 3, 1'b1, -1, 0, "R9 same cycle tie");
    run_meas(5, 1, 1'b1, -1, 0, "R9 same cycle reversed");

    // R7 second start ignored
    run_meas(0, 120, 1'b1, 40, 0, "R7");

    // R8 saturation boundary and overflow
    run_meas(0, 2045, 1'b1, -1, 0, "R8 at max count");
    chk_byte(0, 64'hFD);
    chk_byte(1, 64'h07);
    chk_byte(2, 64'h00);
    run_meas(0, 2047, 1'b1, -1, 0, "R8 past max count");
    run_meas(4, 0, 1'b0, -1, 0, "R8 no stop");
    chk_byte(2, 64'hFF);
    chk_byte(3, 64'h00);

    // R1/R2 constrained random
    for (int k = 0; k < 30; k++) begin
      int a;
      a = int'($urandom_range(0, 7));
      run_meas(a, a + int'($urandom_range(0, 300)), 1'b1, -1,
               int'($urandom_range(0, 30)), "R1/R2 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ph[0]);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule